// File: doc/BRIEF.md
# Descriptor-Walking Bus-Master DMA Engine

This block moves 32-bit data words between a device-side stream and system memory. The path is laid out by a table of region descriptors that software builds in memory. Software writes the table address into a pointer register. It then sets the start bit in the command register, with a direction bit that selects device-to-memory or memory-to-device. From that point the engine runs on its own. It reads each 8-byte descriptor, moves the words of that region, and goes on to the next entry. It stops at the entry that carries the end-of-table flag.

The device marks its final word with a `dev_last` flag on that word's handshake. The engine compares where the device stopped with where the table stopped. The outcome is held in a status byte, and from that byte software can tell three cases apart: the two lengths were equal, the table ran out first, or the table had regions left over. The interrupt output follows the status interrupt bit. Software clears that bit by writing 1 to it. Writing 0 to the start bit aborts a transfer at any point.

Top module: `prd_dma_engine`

## Requirements
- R1: After reset the command, status and pointer registers read 0, `irq` is low and `mem_req` is low.
- R2: Register offsets are as follows. Offset 0 is the command byte: bit 0 starts the engine, and bit 3 = 1 selects device-to-memory. Offset 2 is the status byte: bit 0 ACTIVE, bit 1 ERROR, bit 2 INTR. Offset 4 is the table pointer, whose bits 1:0 always read 0. A read returns the value one clock after the address is presented.
- R3: Descriptor i is read as two words. The word at pointer+8i is the buffer address. The word at pointer+8i+4 is the control word: bits 15:0 give the byte count, where 0 means 65536, and bit 31 flags the last entry.
- R4: In device-to-memory mode, each word taken from the device is written to memory at consecutive word addresses within the current region, and nowhere else.
- R5: In memory-to-device mode, each word is read from consecutive region addresses and offered to the device. Data stays stable while the device is not ready.
- R6: When the device's last word is also the last word of the flagged entry, status ends as 0x04 (INTR only).
- R7: When the flagged entry is exhausted before the device's last word, status ends as 0x00 and no interrupt is raised.
- R8: When the device's last word arrives while table space remains, status becomes 0x05 (ACTIVE and INTR) and memory traffic stops. A later write of 0 to the start bit leaves 0x04.
- R9: Writing 0 to the start bit during a transfer clears ACTIVE at once, stops all further memory requests and leaves INTR unchanged.
- R10: Writing 1 to INTR or ERROR in the status byte clears that bit. A write to the ACTIVE bit has no effect.
- R11: `irq` is high exactly while INTR is set.
- R12: If the table holds MAX_ENTRIES entries and none of them is flagged last, the engine stops at the end of the final one with status 0x06 (ERROR and INTR).
- R13: If a status write clearing INTR lands in the same cycle that the engine sets INTR, INTR ends up set.
- R14: When a region is exhausted and its entry is not flagged last, the engine fetches the next descriptor and continues there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 32 | Register write data, right-justified |
| reg_rdata | output | 32 | Registered read data for reg_addr |
| mem_req | output | 1 | Memory request, held until mem_ack |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, valid with mem_ack |
| mem_ack | input | 1 | Memory request completed |
| dev_rx_data | input | DATA_W | Word from the device |
| dev_rx_valid | input | 1 | Device word valid |
| dev_rx_ready | output | 1 | Engine accepts a device word |
| dev_tx_data | output | DATA_W | Word to the device |
| dev_tx_valid | output | 1 | Word to the device valid |
| dev_tx_ready | input | 1 | Device accepts the word |
| dev_last | input | 1 | The word handshaken this cycle is the device's final one |
| irq | output | 1 | Interrupt, follows status INTR |

## Verification
The engine setting INTR at the end of a transfer and a software write clearing INTR can fall in the same clock cycle. The bench forces this overlap: its memory model raises a status write with INTR=1 in exactly the cycle it acknowledges the final data write of an exactly-matched transfer. After that cycle the status must read 0x04, so the new completion wins over the stale clear.

// File: rtl/prd_dma_pkg.sv
package prd_dma_pkg;
  localparam int REG_CMD  = 0;
  localparam int REG_STAT = 2;
  localparam int REG_PTR  = 4;

  localparam int CMD_GO_BIT     = 0;
  localparam int CMD_TOMEM_BIT  = 3;
  localparam int ST_ACTIVE_BIT  = 0;
  localparam int ST_ERROR_BIT   = 1;
  localparam int ST_INTR_BIT    = 2;
  localparam int DESC_LAST_BIT  = 31;

  typedef enum logic [2:0] {
    W_IDLE, W_DADDR, W_DCNT, W_RXGET, W_MEMWR, W_MEMRD, W_TXPUT, W_HOLD
  } walk_state_t;

  // completion outcome of a run, at most one per cycle
  typedef struct packed {
    logic hit;      // table and device ended together
    logic under;    // table ended first
    logic over;     // device ended first
    logic runaway;  // entry limit reached with no last flag
  } walk_evt_t;
endpackage

// File: rtl/prd_dma_regs.sv
module prd_dma_regs
  import prd_dma_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [2:0]        addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  walk_evt_t         evt,
  output logic              go,
  output logic              stop,
  output logic              dir_now,
  output logic [ADDR_W-1:0] tbl_base,
  output logic              active,
  output logic              intr,
  output logic              irq
);
  logic start_q, dir_q, active_q, err_q, intr_q;
  logic [ADDR_W-1:0] ptr_q;
  logic wr_cmd, wr_stat, wr_ptr;

  assign wr_cmd  = wr && (addr == 3'(REG_CMD));
  assign wr_stat = wr && (addr == 3'(REG_STAT));
  assign wr_ptr  = wr && (addr == 3'(REG_PTR));

  assign go      = wr_cmd && wdata[CMD_GO_BIT] && !start_q && !active_q;
  assign stop    = wr_cmd && !wdata[CMD_GO_BIT] && start_q;
  assign dir_now = wdata[CMD_TOMEM_BIT];
  assign tbl_base = ptr_q;
  assign active  = active_q;
  assign intr    = intr_q;
  assign irq     = intr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q  <= 1'b0;
      dir_q    <= 1'b0;
      active_q <= 1'b0;
      err_q    <= 1'b0;
      intr_q   <= 1'b0;
      ptr_q    <= '0;
    end else begin
      if (wr_cmd) begin
        start_q <= wdata[CMD_GO_BIT];
        dir_q   <= wdata[CMD_TOMEM_BIT];
      end
      if (wr_ptr)
        ptr_q <= {wdata[ADDR_W-1:2], 2'b00};

      if (go)
        active_q <= 1'b1;
      else if (stop || evt.hit || evt.under || evt.runaway)
        active_q <= 1'b0;

      // a fresh completion outranks a clear landing in the same cycle
      if (evt.hit || evt.over || evt.runaway)
        intr_q <= 1'b1;
      else if (wr_stat && wdata[ST_INTR_BIT])
        intr_q <= 1'b0;

      if (evt.runaway)
        err_q <= 1'b1;
      else if (wr_stat && wdata[ST_ERROR_BIT])
        err_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      case (addr)
        3'(REG_CMD):  rdata <= {28'd0, dir_q, 2'b00, start_q};
        3'(REG_STAT): rdata <= {29'd0, intr_q, err_q, active_q};
        3'(REG_PTR):  rdata <= 32'(ptr_q);
        default:      rdata <= '0;
      endcase
    end
  end

  logic unused_wdata;
  assign unused_wdata = ^{wdata[31:ADDR_W > 31 ? 31 : ADDR_W], wdata[1]};
endmodule

// File: rtl/prd_dma_walker.sv
module prd_dma_walker
  import prd_dma_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int MAX_ENTRIES = 8,
  parameter int CNT_BITS    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic              stop,
  input  logic              to_mem,
  input  logic [ADDR_W-1:0] tbl_base,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  output logic [DATA_W-1:0] tx_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  input  logic              dev_last,
  output walk_evt_t         evt
);
  localparam int IDX_W = (MAX_ENTRIES > 1) ? $clog2(MAX_ENTRIES) : 1;
  localparam int REM_W = CNT_BITS + 1;
  localparam int BEAT  = DATA_W / 8;

  walk_state_t       state;
  logic [IDX_W-1:0]  idx;
  logic [ADDR_W-1:0] base_q, buf_q;
  logic [REM_W-1:0]  rem_q;
  logic              eot_q, mode_q, last_q;
  logic [DATA_W-1:0] data_q;

  logic [ADDR_W-1:0] desc_addr;
  logic [REM_W-1:0]  rem_load;
  logic beat_end, beat_last, region_end, table_end, at_limit;

  assign desc_addr = base_q + {{(ADDR_W-IDX_W-3){1'b0}}, idx, 3'b000};
  assign rem_load  = (mem_rdata[CNT_BITS-1:0] == '0) ? REM_W'(1) << CNT_BITS
                                                     : {1'b0, mem_rdata[CNT_BITS-1:0]};

  assign mem_req  = (state == W_DADDR) || (state == W_DCNT) ||
                    (state == W_MEMWR) || (state == W_MEMRD);
  assign mem_we   = (state == W_MEMWR);
  assign mem_addr = (state == W_DADDR) ? desc_addr :
                    (state == W_DCNT)  ? desc_addr + ADDR_W'(4) : buf_q;
  assign mem_wdata = data_q;
  assign rx_ready  = (state == W_RXGET);
  assign tx_valid  = (state == W_TXPUT);
  assign tx_data   = data_q;

  assign beat_end   = ((state == W_MEMWR) && mem_ack) || ((state == W_TXPUT) && tx_ready);
  assign beat_last  = (state == W_MEMWR) ? last_q : dev_last;
  assign region_end = (rem_q <= REM_W'(BEAT));
  assign table_end  = region_end && eot_q;
  assign at_limit   = (idx == IDX_W'(MAX_ENTRIES - 1));

  always_comb begin
    evt = '0;
    if (beat_end && !stop) begin
      evt.hit     = beat_last && table_end;
      evt.over    = beat_last && !table_end;
      evt.under   = !beat_last && table_end;
      evt.runaway = !beat_last && region_end && !eot_q && at_limit;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= W_IDLE;
      idx    <= '0;
      base_q <= '0;
      buf_q  <= '0;
      rem_q  <= '0;
      eot_q  <= 1'b0;
      mode_q <= 1'b0;
      last_q <= 1'b0;
      data_q <= '0;
    end else if (stop) begin
      state <= W_IDLE;
    end else begin
      case (state)
        W_IDLE: if (go) begin
          base_q <= tbl_base;
          mode_q <= to_mem;
          idx    <= '0;
          state  <= W_DADDR;
        end
        W_DADDR: if (mem_ack) begin
          buf_q <= {mem_rdata[ADDR_W-1:2], 2'b00};
          state <= W_DCNT;
        end
        W_DCNT: if (mem_ack) begin
          rem_q <= rem_load;
          eot_q <= mem_rdata[DESC_LAST_BIT];
          state <= mode_q ? W_RXGET : W_MEMRD;
        end
        W_RXGET: if (rx_valid) begin
          data_q <= rx_data;
          last_q <= dev_last;
          state  <= W_MEMWR;
        end
        W_MEMRD: if (mem_ack) begin
          data_q <= mem_rdata;
          state  <= W_TXPUT;
        end
        W_MEMWR, W_TXPUT: if (beat_end) begin
          if (beat_last) begin
            state <= table_end ? W_IDLE : W_HOLD;
          end else if (region_end) begin
            if (eot_q || at_limit) begin
              state <= W_IDLE;
            end else begin
              idx   <= idx + 1'b1;
              state <= W_DADDR;
            end
          end else begin
            buf_q <= buf_q + ADDR_W'(BEAT);
            rem_q <= rem_q - REM_W'(BEAT);
            state <= mode_q ? W_RXGET : W_MEMRD;
          end
        end
        W_HOLD: state <= W_HOLD;
        default: state <= W_IDLE;
      endcase
    end
  end

  logic unused_rdata;
  assign unused_rdata = ^{mem_rdata[DESC_LAST_BIT-1:CNT_BITS], mem_rdata[1:0]};
endmodule

// File: rtl/prd_dma_engine.sv
module prd_dma_engine
  import prd_dma_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int MAX_ENTRIES = 8,
  parameter int CNT_BITS    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] dev_rx_data,
  input  logic              dev_rx_valid,
  output logic              dev_rx_ready,
  output logic [DATA_W-1:0] dev_tx_data,
  output logic              dev_tx_valid,
  input  logic              dev_tx_ready,
  input  logic              dev_last,
  output logic              irq
);
  walk_evt_t         evt;
  logic              go, stop, dir_now, active, intr;
  logic [ADDR_W-1:0] tbl_base;

  prd_dma_regs #(.ADDR_W(ADDR_W)) regs_i (
    .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .evt(evt), .go(go), .stop(stop), .dir_now(dir_now),
    .tbl_base(tbl_base), .active(active), .intr(intr), .irq(irq)
  );

  prd_dma_walker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAX_ENTRIES(MAX_ENTRIES), .CNT_BITS(CNT_BITS)
  ) walk_i (
    .clk(clk), .rst(rst), .go(go), .stop(stop), .to_mem(dir_now), .tbl_base(tbl_base),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .rx_data(dev_rx_data), .rx_valid(dev_rx_valid), .rx_ready(dev_rx_ready),
    .tx_data(dev_tx_data), .tx_valid(dev_tx_valid), .tx_ready(dev_tx_ready),
    .dev_last(dev_last), .evt(evt)
  );
endmodule

// File: rtl/prd_dma_sva.sv
module prd_dma_sva
  import prd_dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              mem_req,
  input logic              mem_ack,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [DATA_W-1:0] tx_data,
  input logic              go,
  input logic              stop,
  input walk_evt_t         evt,
  input logic              active,
  input logic              intr,
  input logic              irq
);
  assert_req_held_R4: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  assert_tx_held_R5: assert property (@(posedge clk) disable iff (rst)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

  assert_one_outcome_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0({evt.hit, evt.under, evt.over, evt.runaway}));

  assert_under_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    evt.under && !intr |=> !active && !intr);

  assert_over_holds_R8: assert property (@(posedge clk) disable iff (rst)
    evt.over |=> active && intr && !mem_req);

  assert_stop_halts_R9: assert property (@(posedge clk) disable iff (rst)
    stop |=> !active && !mem_req);

  assert_req_only_active_R9: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> active);

  assert_irq_from_event_R11: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(evt.hit || evt.over || evt.runaway));

  assert_set_wins_R13: assert property (@(posedge clk) disable iff (rst)
    evt.hit |=> intr);

  assert_go_arms_R2: assert property (@(posedge clk) disable iff (rst)
    go |=> active);
endmodule

bind prd_dma_engine prd_dma_sva #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) sva_i (
  .clk(clk), .rst(rst), .mem_req(mem_req), .mem_ack(mem_ack), .mem_we(mem_we),
  .mem_addr(mem_addr), .tx_valid(dev_tx_valid), .tx_ready(dev_tx_ready),
  .tx_data(dev_tx_data), .go(go), .stop(stop), .evt(evt), .active(active),
  .intr(intr), .irq(irq)
);

// File: tb/prd_dma_engine_tb_top.sv
module prd_dma_engine_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic        tb_wr = 1'b0, side_wr = 1'b0;
  logic [2:0]  tb_addr = '0;
  logic [31:0] tb_wdata = '0;
  logic        reg_wr;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        mem_req, mem_we, mem_ack = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic [31:0] dev_rx_data = '0, dev_tx_data;
  logic        dev_rx_valid = 1'b0, dev_rx_ready, dev_tx_valid, dev_tx_ready = 1'b0;
  logic        dev_last = 1'b0, irq;

  assign reg_wr    = tb_wr | side_wr;
  assign reg_addr  = side_wr ? 3'd2 : tb_addr;
  assign reg_wdata = side_wr ? 32'h4 : tb_wdata;

  prd_dma_engine dut_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .dev_rx_data(dev_rx_data), .dev_rx_valid(dev_rx_valid), .dev_rx_ready(dev_rx_ready),
    .dev_tx_data(dev_tx_data), .dev_tx_valid(dev_tx_valid), .dev_tx_ready(dev_tx_ready),
    .dev_last(dev_last), .irq(irq)
  );

  int checks = 0, bad = 0, cyc = 0, wr_count = 0, w1c_at = -1;
  logic [31:0] mem_m [0:1023];
  logic [63:0] wr_q[$];
  logic [31:0] tx_q[$];

  // device model configuration: 0 idle, 1 feeds words, 2 takes words
  int dev_mode = 0, dev_n = 0, dev_idx = 0;
  logic [31:0] dev_base = '0, tx_cap = '0;
  logic pend = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory model and write scoreboard monitor
  always @(negedge clk) begin
    side_wr = 1'b0;
    if (mem_ack) begin
      mem_ack = 1'b0;
    end else if (mem_req && !rst) begin
      mem_ack   = 1'b1;
      mem_rdata = mem_m[mem_addr[11:2]];
      if (mem_we) begin
        logic [63:0] e;
        mem_m[mem_addr[11:2]] = mem_wdata;
        wr_count++;
        if (wr_q.size() == 0) begin
          chk("R4 unexpected write addr", mem_addr, 32'hFFFF_FFFF);
        end else begin
          e = wr_q.pop_front();
          chk("R4 write addr", mem_addr, e[63:32]);
          chk("R4 write data", mem_wdata, e[31:0]);
        end
        if (wr_count == w1c_at) side_wr = 1'b1;
      end
    end
  end

  // device model and word-to-device monitor
  always @(negedge clk) begin
    if (pend) begin
      if (dev_mode == 2) begin
        if (tx_q.size() == 0) chk("R5 unexpected word", tx_cap, 32'hFFFF_FFFF);
        else chk("R5 word to device", tx_cap, tx_q.pop_front());
      end
      dev_idx++;
    end
    dev_rx_valid = (dev_mode == 1) && (dev_idx < dev_n);
    dev_rx_data  = dev_base + 32'(dev_idx);
    dev_tx_ready = (dev_mode == 2) && (dev_idx < dev_n);
    dev_last     = (dev_mode != 0) && (dev_idx == dev_n - 1);
    pend = (dev_rx_valid && dev_rx_ready) || (dev_tx_valid && dev_tx_ready);
    if (dev_tx_valid && dev_tx_ready) tx_cap = dev_tx_data;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); tb_wr = 1'b1; tb_addr = a; tb_wdata = d;
    @(negedge clk); tb_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); tb_addr = a;
    @(negedge clk); d = reg_rdata;
  endtask

  task automatic put_desc(input int tbl, input int i, input logic [31:0] a, input logic [31:0] c);
    mem_m[(tbl >> 2) + 2*i]     = a;
    mem_m[(tbl >> 2) + 2*i + 1] = c;
  endtask

  task automatic push_rx(input logic [31:0] a, input logic [31:0] d);
    wr_q.push_back({a, d});
  endtask

  task automatic start_run(input int tbl, input logic tomem, input int mode,
                           input int n, input logic [31:0] base);
    @(posedge clk); #1;
    dev_mode = mode; dev_n = n; dev_idx = 0; dev_base = base;
    reg_write(3'd4, 32'(tbl));
    reg_write(3'd0, 32'h0);
    reg_write(3'd2, 32'h6);
    reg_write(3'd0, {28'd0, tomem, 3'b001});
  endtask

  task automatic settle();
    repeat (300) @(posedge clk);
  endtask

  logic [31:0] rv;
  int snap;

  initial begin
    for (int i = 0; i < 1024; i++) mem_m[i] = '0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R1 reset state
    reg_read(3'd0, rv); chk("R1 cmd after reset", rv, 32'h0);
    reg_read(3'd2, rv); chk("R1 status after reset", rv, 32'h0);
    reg_read(3'd4, rv); chk("R1 pointer after reset", rv, 32'h0);
    chk("R1 irq after reset", {31'd0, irq}, 32'h0);
    chk("R1 mem_req after reset", {31'd0, mem_req}, 32'h0);

    // R2 pointer alignment
    reg_write(3'd4, 32'h0000_0107);
    reg_read(3'd4, rv); chk("R2 pointer low bits", rv, 32'h0000_0104);

    // R4 R6 R14 exact match across two entries, device to memory
    put_desc(32'h000, 0, 32'h400, 32'd8);
    put_desc(32'h000, 1, 32'h500, 32'h8000_0008);
    push_rx(32'h400, 32'hA000_0000); push_rx(32'h404, 32'hA000_0001);
    push_rx(32'h500, 32'hA000_0002); push_rx(32'h504, 32'hA000_0003);
    start_run(32'h000, 1'b1, 1, 4, 32'hA000_0000);
    reg_read(3'd0, rv); chk("R2 cmd readback", rv, 32'h9);
    settle();
    chk("R14 all writes across entries", 32'(wr_q.size()), 32'h0);
    reg_read(3'd2, rv); chk("R6 exact status", rv, 32'h4);
    chk("R11 irq with INTR", {31'd0, irq}, 32'h1);
    reg_write(3'd2, 32'h1);
    reg_read(3'd2, rv); chk("R10 ACTIVE write ignored", rv, 32'h4);
    reg_write(3'd2, 32'h4);
    reg_read(3'd2, rv); chk("R10 INTR cleared", rv, 32'h0);
    chk("R11 irq low after clear", {31'd0, irq}, 32'h0);

    // R5 R6 memory to device, exact
    put_desc(32'h020, 0, 32'h600, 32'h8000_000C);
    for (int k = 0; k < 3; k++) begin
      mem_m[(32'h600 >> 2) + k] = 32'hB000_0000 + 32'(k);
      tx_q.push_back(32'hB000_0000 + 32'(k));
    end
    start_run(32'h020, 1'b0, 2, 3, 32'h0);
    settle();
    chk("R5 all words delivered", 32'(tx_q.size()), 32'h0);
    reg_read(3'd2, rv); chk("R6 exact status to device", rv, 32'h4);

    // R7 table shorter than device
    put_desc(32'h040, 0, 32'h700, 32'h8000_0008);
    push_rx(32'h700, 32'hC000_0000); push_rx(32'h704, 32'hC000_0001);
    start_run(32'h040, 1'b1, 1, 4, 32'hC000_0000);
    settle();
    chk("R7 writes done", 32'(wr_q.size()), 32'h0);
    reg_read(3'd2, rv); chk("R7 short status", rv, 32'h0);
    chk("R7 irq stays low", {31'd0, irq}, 32'h0);

    // R8 table longer than device
    put_desc(32'h060, 0, 32'h800, 32'h8000_0020);
    push_rx(32'h800, 32'hD000_0000); push_rx(32'h804, 32'hD000_0001);
    start_run(32'h060, 1'b1, 1, 2, 32'hD000_0000);
    settle();
    chk("R8 writes done", 32'(wr_q.size()), 32'h0);
    reg_read(3'd2, rv); chk("R8 long status", rv, 32'h5);
    reg_write(3'd0, 32'h8);
    reg_read(3'd2, rv); chk("R8 status after stop", rv, 32'h4);

    // R9 abort mid-transfer
    put_desc(32'h080, 0, 32'h900, 32'h8000_0040);
    for (int k = 0; k < 16; k++) push_rx(32'h900 + 32'(4*k), 32'hE000_0000 + 32'(k));
    start_run(32'h080, 1'b1, 1, 16, 32'hE000_0000);
    repeat (20) @(posedge clk);
    reg_write(3'd0, 32'h8);
    snap = wr_count;
    reg_read(3'd2, rv); chk("R9 ACTIVE cleared by stop", rv, 32'h0);
    settle();
    chk("R9 no writes after stop", 32'(wr_count), 32'(snap));
    chk("R9 transfer was cut short", {31'd0, (wr_q.size() > 0)}, 32'h1);
    wr_q.delete();

    // R12 entry limit with no last flag (default limit 8)
    for (int i = 0; i < 8; i++) begin
      put_desc(32'h0C0, i, 32'hA00 + 32'(16*i), 32'd4);
      push_rx(32'hA00 + 32'(16*i), 32'hF000_0000 + 32'(i));
    end
    start_run(32'h0C0, 1'b1, 1, 20, 32'hF000_0000);
    settle();
    chk("R12 writes done", 32'(wr_q.size()), 32'h0);
    reg_read(3'd2, rv); chk("R12 runaway status", rv, 32'h6);
    chk("R11 irq on runaway", {31'd0, irq}, 32'h1);

    // R3 zero count means 64 KiB: three words leave the table long
    put_desc(32'h100, 0, 32'hB00, 32'h8000_0000);
    for (int k = 0; k < 3; k++) push_rx(32'hB00 + 32'(4*k), 32'h1000_0000 + 32'(k));
    start_run(32'h100, 1'b1, 1, 3, 32'h1000_0000);
    settle();
    chk("R3 writes done", 32'(wr_q.size()), 32'h0);
    reg_read(3'd2, rv); chk("R3 zero count is large", rv, 32'h5);
    reg_write(3'd0, 32'h0);

    // R13 INTR clear in the completion cycle
    put_desc(32'h120, 0, 32'hC00, 32'h8000_0008);
    push_rx(32'hC00, 32'h2000_0000); push_rx(32'hC04, 32'h2000_0001);
    start_run(32'h120, 1'b1, 1, 2, 32'h2000_0000);
    w1c_at = wr_count + 2;
    settle();
    w1c_at = -1;
    reg_read(3'd2, rv); chk("R13 set wins over clear", rv, 32'h4);

    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule